// File: doc/BRIEF.md
# Viterbi Survivor Traceback with Forward-Order Bit Packing

This block finishes a 16-state, rate one-half Viterbi decode. After the forward pass has written one 16-bit decision word for each symbol interval into a memory, the block walks those words from the newest interval back to the oldest. It starts in state 0, which the encoder's zero tail guarantees. At each interval it picks the decision bit that belongs to the current state, uses that bit to form the predecessor state, and recovers one decoded data bit.

Bits are recovered newest first. The block drops the bits of the four tail intervals. It reverses each group of sixteen data bits into a 16-bit word with the oldest bit in the MSB, and keeps the words in a small frame buffer. When the walk has finished, it streams the words out oldest first. The output uses valid/ready. A word is transferred on every cycle where both are high. While ready is low, the block holds valid and the word steady and loses nothing. Once valid is up, it stays up until the last word of the frame has been taken. Start, frame length, busy and done are plain level/strobe pins.

Top module: `vit_traceback`

## Requirements
- R1: After reset, busy, done, mem_rd_en and out_valid are all low.
- R2: A frame of N words has L = 16·N + 4 intervals. The block reads decision-word addresses L-1, L-2, ... down to 0, one read every two clock cycles. Read data is used one cycle after the address is presented.
- R3: For current state j, the decision bit is taken from position 2·(j mod 8) + j[3] counted from the word's MSB (position 0 = bit 15, position 15 = bit 0). No other bit of the word affects the result.
- R4: The walk starts at state 0 at the end of the last interval. The state before an interval is ((j << 1) | b) mod 16, where b is the selected decision bit.
- R5: The decoded bit of an interval is bit 3 of the state reached at the end of that interval. The four tail intervals (addresses 16·N to 16·N+3) are traced but produce no output bit.
- R6: Exactly N words are output, word 0 first. Word w carries the data bit of interval 16·w + k in bit 15 − k.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change on the next cycle.
- R8: done is high for exactly one cycle, in the cycle after the handshake of the last word. busy is high from the cycle after an accepted start until that same cycle, where it returns low.
- R9: start is ignored while busy is high, and also when frame_words is 0 or larger than MAX_WORDS (default 8).
- R10: out_valid first rises exactly 2·L cycles after the clock edge that accepts start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle strobe that launches a frame |
| frame_words | input | 4 | Frame length in 16-bit data words (1..MAX_WORDS) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after the final word is accepted |
| mem_rd_en | output | 1 | Decision-memory read strobe |
| mem_addr | output | 8 | Interval index to read |
| mem_rd_data | input | 16 | Decision word, valid one cycle after the read |
| out_valid | output | 1 | Packed word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 16 | Packed decoded word |

## Verification
The bench fills the decision memory with chosen bits. Only the bit on the true path is meaningful, and every other bit is set to the opposite value or to noise. A design that reads the wrong position, or mirrors the bit index, therefore walks off the path and emits wrong words. Frames of one, two, three, four and eight words, built from all-zero, all-one, alternating and pseudo-random data, expose several faults: a wrong tail count, which shifts every bit; a missing reversal, which flips each word end to end; and a reversed word order. Random back-pressure checks that held words stay put. The bench also checks the exact descending address sequence and the 2·L latency. Start pulses given while busy or with an out-of-range length must leave the frame untouched.

// File: rtl/vtb_pkg.sv
package vtb_pkg;
  localparam int SBITS = 4;
  localparam int WBITS = 16;

  typedef logic [SBITS-1:0] trel_state_t;
  typedef logic [WBITS-1:0] dec_word_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_FETCH,
    PH_EVAL,
    PH_DRAIN
  } phase_t;

  // Position from the MSB of the decision belonging to state j: 2*(j mod 8) + j[3]
  function automatic logic [SBITS-1:0] decision_pos(input trel_state_t j);
    return {j[SBITS-2:0], j[SBITS-1]};
  endfunction
endpackage

// File: rtl/vtb_stepper.sv
module vtb_stepper
  import vtb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        step,
  input  dec_word_t   trn_word,
  output logic        dec_bit,
  output trel_state_t cur_state
);
  logic [SBITS-1:0] pos;
  logic             sel;

  always_comb begin
    pos     = decision_pos(cur_state);
    sel     = trn_word[4'(WBITS-1) - pos];
    dec_bit = cur_state[SBITS-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     cur_state <= '0;
    else if (load)  cur_state <= '0;
    else if (step)  cur_state <= {cur_state[SBITS-2:0], sel};
  end
endmodule

// File: rtl/vtb_sequencer.sv
module vtb_sequencer
  import vtb_pkg::*;
#(
  parameter int MAX_WORDS = 8,
  parameter int TAIL      = 4,
  localparam int NW = $clog2(MAX_WORDS + 1),
  localparam int AW = $clog2(MAX_WORDS * WBITS + TAIL),
  localparam int IW = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] frame_words,
  input  logic          drain_done,
  output logic          busy,
  output logic          done,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  output logic          load,
  output logic          step,
  output logic          emit,
  output logic [IW-1:0] word_idx,
  output logic          drain,
  output logic [NW-1:0] nwords
);
  phase_t        phase;
  logic [AW-1:0] t_cnt;
  logic [AW-1:0] data_len;
  logic          len_ok;

  always_comb begin
    len_ok    = (frame_words != '0) && (frame_words <= NW'(MAX_WORDS));
    load      = start && (phase == PH_IDLE) && len_ok;
    data_len  = AW'(nwords) << 4;
    step      = (phase == PH_EVAL);
    emit      = step && (t_cnt < data_len);
    word_idx  = IW'(t_cnt >> 4);
    mem_rd_en = (phase == PH_FETCH);
    mem_addr  = t_cnt;
    drain     = (phase == PH_DRAIN);
    busy      = (phase != PH_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      t_cnt  <= '0;
      nwords <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (load) begin
          nwords <= frame_words;
          t_cnt  <= (AW'(frame_words) << 4) + AW'(TAIL - 1);
          phase  <= PH_FETCH;
        end
        PH_FETCH: phase <= PH_EVAL;
        PH_EVAL: begin
          if (t_cnt == '0) phase <= PH_DRAIN;
          else begin
            t_cnt <= t_cnt - AW'(1);
            phase <= PH_FETCH;
          end
        end
        PH_DRAIN: if (drain_done) begin
          phase <= PH_IDLE;
          done  <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vtb_packer.sv
module vtb_packer
  import vtb_pkg::*;
#(
  parameter int MAX_WORDS = 8,
  localparam int NW = $clog2(MAX_WORDS + 1),
  localparam int IW = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          emit,
  input  logic          bit_in,
  input  logic [IW-1:0] word_idx,
  input  logic          drain,
  input  logic [NW-1:0] nwords,
  input  logic          out_ready,
  output logic          out_valid,
  output dec_word_t     out_data,
  output logic          drain_done
);
  dec_word_t     acc;
  logic [3:0]    bcnt;
  logic          wr_en;
  dec_word_t     wr_word;
  dec_word_t     words_q [MAX_WORDS];
  logic [IW-1:0] rptr;
  logic          fire;

  // Bits arrive newest first; shifting in at the MSB leaves the oldest bit on top.
  always_comb begin
    wr_word = {bit_in, acc[WBITS-1:1]};
    wr_en   = emit && (bcnt == 4'd15);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      bcnt <= '0;
    end else if (clear) begin
      bcnt <= '0;
    end else if (emit) begin
      acc  <= wr_word;
      bcnt <= bcnt + 4'd1;
    end
  end

  for (genvar g = 0; g < MAX_WORDS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                 words_q[g] <= '0;
      else if (wr_en && (word_idx == IW'(g)))     words_q[g] <= wr_word;
    end
  end

  always_comb begin
    out_valid  = drain;
    out_data   = words_q[rptr];
    fire       = out_valid && out_ready;
    drain_done = fire && ((NW'(rptr) + NW'(1)) == nwords);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rptr <= '0;
    else if (clear)  rptr <= '0;
    else if (fire)   rptr <= rptr + IW'(1);
  end
endmodule

// File: rtl/vit_traceback.sv
module vit_traceback
  import vtb_pkg::*;
#(
  parameter int MAX_WORDS = 8,
  parameter int TAIL      = 4,
  localparam int NW = $clog2(MAX_WORDS + 1),
  localparam int AW = $clog2(MAX_WORDS * WBITS + TAIL),
  localparam int IW = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] frame_words,
  output logic          busy,
  output logic          done,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [15:0]   mem_rd_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [15:0]   out_data
);
  logic          load, step, emit, drain, drain_done, dec_bit;
  logic [IW-1:0] word_idx;
  logic [NW-1:0] nwords;
  trel_state_t   cur_state;

  vtb_sequencer #(.MAX_WORDS(MAX_WORDS), .TAIL(TAIL)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_words(frame_words),
    .drain_done(drain_done), .busy(busy), .done(done),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .load(load), .step(step),
    .emit(emit), .word_idx(word_idx), .drain(drain), .nwords(nwords)
  );

  vtb_stepper u_step (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .trn_word(mem_rd_data), .dec_bit(dec_bit), .cur_state(cur_state)
  );

  vtb_packer #(.MAX_WORDS(MAX_WORDS)) u_pack (
    .clk(clk), .rst_n(rst_n), .clear(load), .emit(emit), .bit_in(dec_bit),
    .word_idx(word_idx), .drain(drain), .nwords(nwords),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .drain_done(drain_done)
  );
endmodule

// File: rtl/vit_traceback_chk.sv
module vit_traceback_chk #(
  parameter int MAX_WORDS = 8,
  parameter int TAIL      = 4,
  localparam int AW = $clog2(MAX_WORDS * 16 + TAIL)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_addr,
  input logic          out_valid,
  input logic          out_ready,
  input logic [15:0]   out_data
);
  logic [AW-1:0] last_a;
  logic          have_a;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) begin
      have_a <= 1'b0;
      last_a <= '0;
    end else if (mem_rd_en) begin
      have_a <= 1'b1;
      last_a <= mem_addr;
    end
  end

  AST_READ_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);                                         // R2
  AST_ADDR_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && have_a) |-> (mem_addr == last_a - AW'(1)));          // R2
  AST_NO_READ_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !mem_rd_en);                                         // R10
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));   // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                   // R8
  AST_DONE_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(out_valid && out_ready) && !busy));                // R8
  AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);                                               // R8
endmodule

bind vit_traceback vit_traceback_chk #(.MAX_WORDS(MAX_WORDS), .TAIL(TAIL)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_rd_en(mem_rd_en),
  .mem_addr(mem_addr), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data)
);

// File: tb/vit_traceback_test.sv
module vit_traceback_test;
  localparam int MAXW = 8;
  localparam int TL   = 4;
  localparam int AW   = $clog2(MAXW * 16 + TL);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    frame_words = '0;
  logic          busy, done, mem_rd_en, out_valid;
  logic          out_ready = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_rd_data = '0;
  logic [15:0]   out_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int exp_addr = 0;
  int done_cnt = 0;
  int rmode = 0;
  logic [15:0] rlf = 16'hACE1;
  logic [15:0] tmem [0:MAXW*16+TL-1];
  logic        dbits [0:MAXW*16-1];
  logic [15:0] exp_q [$];
  logic        held_pend = 1'b0;
  logic [15:0] held_word = '0;

  always #2 clk = ~clk;   // 250 MHz

  vit_traceback #(.MAX_WORDS(MAXW), .TAIL(TL)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_words(frame_words),
    .busy(busy), .done(done), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rd_data(mem_rd_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsr(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // memory model: one cycle read latency (R2)
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= tmem[mem_addr];

  always @(posedge clk) begin
    cycles++;
    #1;
    rlf = lfsr(rlf);
    out_ready = (rmode == 0) ? 1'b1 : rlf[3];
  end

  // scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    if (mem_rd_en) begin
      chk(int'(mem_addr) == exp_addr, "R2", "read address", 32'(mem_addr), 32'(exp_addr));
      exp_addr--;
    end
    if (held_pend)
      chk(out_valid && out_data == held_word, "R7", "held word", {15'd0, out_valid, out_data}, {16'd1, held_word});
    held_pend = out_valid && !out_ready;
    held_word = out_data;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(0, "R5", "extra output word", 32'(out_data), 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(out_data == e, "R6", "packed word (R3 R4 R5 bits)", 32'(out_data), 32'(e));
      end
    end
    if (done) done_cnt++;
  end

  // R3 R4 R5: encoder model builds the decision memory
  task automatic build_frame(input int nw, input int pat);
    logic [3:0]  s, ns;
    logic [15:0] g, w;
    logic        d;
    int          pos;
    g = 16'h1D2B + 16'(pat);
    s = 4'd0;
    for (int t = 0; t < nw * 16; t++) begin
      case (pat)
        0: dbits[t] = 1'b0;
        1: dbits[t] = 1'b1;
        2: dbits[t] = t[0];
        default: begin g = lfsr(g); dbits[t] = g[5] ^ g[11]; end
      endcase
    end
    for (int t = 0; t < nw * 16 + TL; t++) begin
      d  = (t < nw * 16) ? dbits[t] : 1'b0;
      ns = {d, s[3:1]};
      g  = lfsr(g);
      pos = 2 * int'(ns[2:0]) + int'(ns[3]);
      w = (pat == 0) ? 16'hFFFF : (pat == 1) ? 16'h0000 : g;
      if (pat < 2) w = ~{16{s[0]}};
      w[15 - pos] = s[0];
      tmem[t] = w;
      s = ns;
    end
    for (int wi = 0; wi < nw; wi++) begin
      logic [15:0] ew;
      for (int k = 0; k < 16; k++) ew[15 - k] = dbits[16 * wi + k];
      exp_q.push_back(ew);
    end
  endtask

  task automatic run_frame(input int nw, input int pat, input int rm);
    int n, dc0;
    rmode = rm;
    build_frame(nw, pat);
    exp_addr = nw * 16 + TL - 1;
    dc0 = done_cnt;
    @(posedge clk); #1;
    start = 1'b1; frame_words = 4'(nw);
    @(posedge clk); #1;
    start = 1'b0;
    chk(busy, "R8", "busy after start", 32'(busy), 1);
    n = 0;
    while (!out_valid && cycles < 150000) begin
      @(posedge clk); #1;
      n++;
      start = (n == 5);           // R9: ignored while busy
      if (n == 5) frame_words = 4'd1;
    end
    start = 1'b0;
    chk(n == 2 * (nw * 16 + TL), "R10", "cycles to first word", 32'(n), 32'(2 * (nw * 16 + TL)));
    while (!done && cycles < 150000) begin @(posedge clk); #1; end
    chk(!busy, "R8", "busy low with done", 32'(busy), 0);
    chk(exp_q.size() == 0, "R5", "words left unsent", 32'(exp_q.size()), 0);
    chk(exp_addr == -1, "R2", "reads per frame", 32'(exp_addr), 32'hFFFFFFFF);
    @(posedge clk); #1;
    chk(!done && done_cnt == dc0 + 1, "R8", "single done pulse", 32'(done_cnt - dc0), 1);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!busy && !done && !mem_rd_en && !out_valid, "R1", "reset outputs",
        {28'd0, busy, done, mem_rd_en, out_valid}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    run_frame(1, 0, 0);
    run_frame(2, 1, 1);
    run_frame(3, 2, 1);
    run_frame(8, 3, 1);
    run_frame(4, 3, 0);
    // R9: illegal lengths ignored
    start = 1'b1; frame_words = 4'd0;
    @(posedge clk); #1;
    chk(!busy && !mem_rd_en, "R9", "zero length ignored", {30'd0, busy, mem_rd_en}, 0);
    frame_words = 4'd9;
    @(posedge clk); #1;
    start = 1'b0;
    chk(!busy && !mem_rd_en, "R9", "oversize length ignored", {30'd0, busy, mem_rd_en}, 0);
    @(posedge clk); #1;
    chk(!busy && !out_valid, "R9", "still idle", {30'd0, busy, out_valid}, 0);
    if (cycles >= 150000) chk(0, "R8", "watchdog expired", 32'(cycles), 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    chk(0, "R8", "watchdog expired", 32'(cycles), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule